// File: doc/BRIEF.md
# Halfword-Packing Serial Data Register

This block sits between a 16-bit bus data port and the byte-wide transmit and receive FIFOs of a serial shift engine. When the configured frame length is 8 bits or less, one 16-bit bus write queues two frames and one 16-bit bus read collects two frames. The low byte is always handled first. An 8-bit bus access moves a single frame. When the frame length is above 8 bits, packing is off and every access moves exactly one 16-bit frame. Such a frame fills two byte slots.

On the receive side, a not-empty flag tells software when to read. Its threshold can be switched between one buffered byte and two buffered bytes, and a two-bit fill level is reported as well. When a stream has an odd number of short frames, software raises the threshold-select bit once the level shows a single byte left. The flag then fires for that last frame, and a byte read drains it, so the FIFO never becomes misaligned.

On the transmit side, a bus write that needs more free slots than the FIFO has is discarded whole and sets a sticky overflow flag. Only reset clears that flag. The shift engine side has a valid/take frame port for transmit and a write strobe for received frames.

Top module: `hpk_dreg`

## Requirements
- R1: After reset both FIFOs are empty: txValid=0, rxNotEmpty=0, rxLevel=00, wrOverflow=0.
- R2: With frameLen<=8, a 16-bit write (busWide=1) queues busWData[7:0] as the first frame and busWData[15:8] as the second. The shift side sees each short frame as txFrame={8'h00, frame}.
- R3: An 8-bit access (busWide=0) moves exactly one frame. A short frame uses one byte slot. A long frame (frameLen>8) is written as {8'h00, busWData[7:0]}, and on a read it returns {8'h00, low byte} while removing the whole frame.
- R4: With frameLen<=8, a 16-bit read returns the earlier received frame in busRData[7:0] and the later one in busRData[15:8], and removes both.
- R5: A 16-bit read with only one byte buffered returns {8'h00, that byte} and removes only that entry.
- R6: With rxThreshOne=0, rxNotEmpty is high only when at least two bytes are buffered.
- R7: With rxThreshOne=1, rxNotEmpty is high when at least one byte is buffered.
- R8: For an odd frame count, when rxLevel=01, setting rxThreshOne raises rxNotEmpty for the last frame. A byte read then returns it and leaves rxLevel=00.
- R9: A write that needs more free transmit slots than are available is dropped, leaves the queued data unchanged, and sets wrOverflow. wrOverflow stays high until reset.
- R10: With frameLen>8, a 16-bit write queues one frame, and txFrame presents it whole once both of its bytes are queued. A received frame occupies two byte slots, and a 16-bit read returns it whole.
- R11: rxLevel encodes the receive fill: 00 empty, 01 at most a quarter full, 10 at most half full, 11 above half. With the default depth of 4 bytes that is 0, 1, 2 and 3-or-4 bytes.
- R12: A read of an empty receive FIFO returns 16'h0000 and changes nothing.
- R13: A received frame that does not fit in the free receive slots is discarded, and the buffered bytes stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameLen | input | 5 | Frame length in bits (4..16); 8 or less enables packing |
| rxThreshOne | input | 1 | 1: not-empty at one byte; 0: at two bytes |
| busWrite | input | 1 | Bus write strobe |
| busRead | input | 1 | Bus read strobe; data is taken from busRData in the same cycle |
| busWide | input | 1 | Access size: 1 = 16-bit, 0 = 8-bit |
| busWData | input | 16 | Bus write data |
| busRData | output | 16 | Bus read data (combinational from the receive FIFO head) |
| txValid | output | 1 | A complete frame is available to the shift engine |
| txFrame | output | 16 | Frame at the head of the transmit FIFO |
| txTake | input | 1 | Shift engine consumes the head frame |
| rxWrite | input | 1 | Shift engine delivers a received frame |
| rxFrame | input | 16 | Received frame |
| rxNotEmpty | output | 1 | Receive data ready at the chosen threshold |
| rxLevel | output | 2 | Receive FIFO fill level code |
| wrOverflow | output | 1 | Sticky flag for a dropped bus write |

## Verification
The assertions assume that frameLen stays constant while either FIFO holds data. They also assume that the shift engine raises txTake only while txValid is high, and never mixes frame lengths inside one stream. The stimulus sets frameLen only when both FIFOs are empty, and it always drains both FIFOs at the end of a scenario. It raises txTake only after it has sampled txValid. The drop checks come from deliberate overfilling and not from any misuse of the shift engine side.

// File: rtl/hpk_pkg.sv
package hpk_pkg;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic [1:0] txPushN;  // bytes written into transmit FIFO
    logic [1:0] txPopN;   // bytes consumed by the shift engine
    logic [1:0] rxPushN;  // bytes written into receive FIFO
    logic [1:0] rxPopN;   // bytes consumed by a bus read
    logic       txHiZero; // second pushed byte is forced to zero
    logic       txHiEn;   // txFrame carries the second head byte
    logic       rdLoEn;   // busRData low byte from head
    logic       rdHiEn;   // busRData high byte from next entry
  } hpk_strobe_t;

  // Fill code: 0 empty, 1 up to a quarter, 2 up to half, 3 above half.
  function automatic logic [1:0] levelCode(input int unsigned cnt,
                                           input int unsigned depth);
    if (cnt == 0)               return 2'b00;
    else if (cnt * 4 <= depth)  return 2'b01;
    else if (cnt * 2 <= depth)  return 2'b10;
    else                        return 2'b11;
  endfunction

endpackage

// File: rtl/hpk_fifo.sv
// Byte FIFO accepting up to two pushes and two pops per cycle.
// DEPTH must be a power of two and at least 2.
module hpk_fifo #(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pushN,
  input  logic [BYTE_W-1:0] pushD0,
  input  logic [BYTE_W-1:0] pushD1,
  input  logic [1:0]        popN,
  output logic [BYTE_W-1:0] head0,
  output logic [BYTE_W-1:0] head1,
  output logic [CNT_W-1:0]  count
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  wrNext;
  logic [PTR_W-1:0]  rdNext;

  assign wrNext = wrPtr + PTR_W'(1);
  assign rdNext = rdPtr + PTR_W'(1);
  assign head0  = mem[rdPtr];
  assign head1  = mem[rdNext];

  always_ff @(posedge clk) begin
    if (pushN != 2'd0) mem[wrPtr] <= pushD0;
    if (pushN == 2'd2) mem[wrNext] <= pushD1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      count <= count + CNT_W'(pushN) - CNT_W'(popN);
    end
  end

  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pushN) <= DEPTH - 32'(count));

  // R12
  pop_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(popN) <= 32'(count));

  // R13
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

endmodule

// File: rtl/hpk_datapath.sv
// Storage and byte steering for both directions.
module hpk_datapath
  import hpk_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hpk_strobe_t       stb,
  input  logic [WORD_W-1:0] busWData,
  input  logic [WORD_W-1:0] rxFrame,
  output logic [WORD_W-1:0] busRData,
  output logic [WORD_W-1:0] txFrame,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);

  logic [BYTE_W-1:0] txHead0, txHead1, rxHead0, rxHead1;
  logic [BYTE_W-1:0] txHiByte;

  // Low byte always goes first; an 8-bit access supplies a zero high byte.
  assign txHiByte = stb.txHiZero ? '0 : busWData[WORD_W-1:BYTE_W];

  hpk_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) txFifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .pushN  (stb.txPushN),
    .pushD0 (busWData[BYTE_W-1:0]),
    .pushD1 (txHiByte),
    .popN   (stb.txPopN),
    .head0  (txHead0),
    .head1  (txHead1),
    .count  (txCount)
  );

  hpk_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) rxFifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .pushN  (stb.rxPushN),
    .pushD0 (rxFrame[BYTE_W-1:0]),
    .pushD1 (rxFrame[WORD_W-1:BYTE_W]),
    .popN   (stb.rxPopN),
    .head0  (rxHead0),
    .head1  (rxHead1),
    .count  (rxCount)
  );

  assign txFrame  = {stb.txHiEn ? txHead1 : {BYTE_W{1'b0}}, txHead0};
  assign busRData = {stb.rdHiEn ? rxHead1 : {BYTE_W{1'b0}},
                     stb.rdLoEn ? rxHead0 : {BYTE_W{1'b0}}};

endmodule

// File: rtl/hpk_ctrl.sv
// Access sizing, threshold and level logic, overflow flag.
module hpk_ctrl
  import hpk_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int BYTE_W   = 8,
  parameter int LEN_W    = 5,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             rxThreshOne,
  input  logic             busWrite,
  input  logic             busRead,
  input  logic             busWide,
  input  logic             txTake,
  input  logic             rxWrite,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output hpk_strobe_t      stb,
  output logic             txValid,
  output logic             rxNotEmpty,
  output logic [1:0]       rxLevel,
  output logic             wrOverflow
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [LEN_W-1:0] PACK_MAX = LEN_W'(BYTE_W);

  logic             packed_;
  logic [1:0]       wrNeed;
  logic [1:0]       rdMax;
  logic [1:0]       frameBytes;
  logic [CNT_W-1:0] txFree;
  logic [CNT_W-1:0] rxFree;
  logic             wrOk;
  logic             rxOk;

  assign packed_    = (frameLen <= PACK_MAX);
  assign frameBytes = packed_ ? 2'd1 : 2'd2;
  assign wrNeed     = (packed_ && !busWide) ? 2'd1 : 2'd2;
  assign rdMax      = (packed_ && !busWide) ? 2'd1 : 2'd2;
  assign txFree     = DEPTH_C - txCount;
  assign rxFree     = DEPTH_C - rxCount;
  assign wrOk       = busWrite && (txFree >= CNT_W'(wrNeed));
  assign rxOk       = rxWrite && (rxFree >= CNT_W'(frameBytes));
  assign txValid    = (txCount >= CNT_W'(frameBytes));

  always_comb begin
    stb          = '0;
    stb.txPushN  = wrOk ? wrNeed : 2'd0;
    stb.txHiZero = !busWide;
    stb.txPopN   = (txTake && txValid) ? frameBytes : 2'd0;
    stb.txHiEn   = !packed_;
    stb.rxPushN  = rxOk ? frameBytes : 2'd0;
    if (busRead) begin
      if (rdMax == 2'd2 && rxCount >= CNT_W'(2)) stb.rxPopN = 2'd2;
      else if (rxCount != '0)                    stb.rxPopN = 2'd1;
      else                                       stb.rxPopN = 2'd0;
    end
    stb.rdLoEn   = (rxCount != '0);
    stb.rdHiEn   = busWide && (rxCount >= CNT_W'(2));
  end

  assign rxNotEmpty = rxThreshOne ? (rxCount != '0) : (rxCount >= CNT_W'(2));
  assign rxLevel    = levelCode(32'(rxCount), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n)                  wrOverflow <= 1'b0;
    else if (busWrite && !wrOk)  wrOverflow <= 1'b1;
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrOverflow |=> wrOverflow);

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrite && busWide && txCount > DEPTH_C - CNT_W'(2)) |=> wrOverflow);

  // R6
  one_byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxThreshOne && rxLevel == 2'b01 && DEPTH >= 4) |-> !rxNotEmpty);

  // R8
  odd_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxThreshOne && rxLevel != 2'b00) |-> rxNotEmpty);

endmodule

// File: rtl/hpk_dreg.sv
// Thin top: control strobes drive the byte datapath.
module hpk_dreg
  import hpk_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 5,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              rxThreshOne,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic              busWide,
  input  logic [WORD_W-1:0] busWData,
  output logic [WORD_W-1:0] busRData,
  output logic              txValid,
  output logic [WORD_W-1:0] txFrame,
  input  logic              txTake,
  input  logic              rxWrite,
  input  logic [WORD_W-1:0] rxFrame,
  output logic              rxNotEmpty,
  output logic [1:0]        rxLevel,
  output logic              wrOverflow
);

  hpk_strobe_t      stb;
  logic [CNT_W-1:0] txCount;
  logic [CNT_W-1:0] rxCount;

  hpk_ctrl #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frameLen    (frameLen),
    .rxThreshOne (rxThreshOne),
    .busWrite    (busWrite),
    .busRead     (busRead),
    .busWide     (busWide),
    .txTake      (txTake),
    .rxWrite     (rxWrite),
    .txCount     (txCount),
    .rxCount     (rxCount),
    .stb         (stb),
    .txValid     (txValid),
    .rxNotEmpty  (rxNotEmpty),
    .rxLevel     (rxLevel),
    .wrOverflow  (wrOverflow)
  );

  hpk_datapath #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .busWData (busWData),
    .rxFrame  (rxFrame),
    .busRData (busRData),
    .txFrame  (txFrame),
    .txCount  (txCount),
    .rxCount  (rxCount)
  );

  // R12
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busRead && rxLevel == 2'b00) |-> (busRData == '0));

  // R2
  short_frame_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && frameLen <= LEN_W'(BYTE_W)) |-> (txFrame[WORD_W-1:BYTE_W] == '0));

endmodule

// File: tb/sim_hpk_dreg.sv
module sim_hpk_dreg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  frameLen;
  logic        rxThreshOne;
  logic        busWrite, busRead, busWide;
  logic [15:0] busWData;
  logic [15:0] busRData;
  logic        txValid;
  logic [15:0] txFrame;
  logic        txTake;
  logic        rxWrite;
  logic [15:0] rxFrame;
  logic        rxNotEmpty;
  logic [1:0]  rxLevel;
  logic        wrOverflow;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  hpk_dreg u0 (
    .clk(clk), .rst_n(rst_n), .frameLen(frameLen), .rxThreshOne(rxThreshOne),
    .busWrite(busWrite), .busRead(busRead), .busWide(busWide),
    .busWData(busWData), .busRData(busRData), .txValid(txValid),
    .txFrame(txFrame), .txTake(txTake), .rxWrite(rxWrite), .rxFrame(rxFrame),
    .rxNotEmpty(rxNotEmpty), .rxLevel(rxLevel), .wrOverflow(wrOverflow)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic busWr(input logic wide, input logic [15:0] d);
    busWrite = 1'b1; busWide = wide; busWData = d;
    tick();
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic wide, output logic [15:0] d);
    busRead = 1'b1; busWide = wide;
    #1 d = busRData;
    tick();
    busRead = 1'b0;
  endtask

  task automatic rxPut(input logic [15:0] d);
    rxWrite = 1'b1; rxFrame = d;
    tick();
    rxWrite = 1'b0;
  endtask

  task automatic txGet(output logic v, output logic [15:0] f);
    #1 v = txValid; f = txFrame;
    txTake = v;
    tick();
    txTake = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0; busWrite = 0; busRead = 0; busWide = 0; busWData = '0;
    txTake = 0; rxWrite = 0; rxFrame = '0; rxThreshOne = 0; frameLen = 5'd8;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic tReset();
    doReset();
    chk("R1 txValid", 16'(txValid), 16'h0);
    chk("R1 rxNotEmpty", 16'(rxNotEmpty), 16'h0);
    chk("R1 rxLevel", 16'(rxLevel), 16'h0);
    chk("R1 wrOverflow", 16'(wrOverflow), 16'h0);
  endtask

  task automatic tPackedWrite();
    logic v; logic [15:0] f;
    frameLen = 5'd8;
    busWr(1'b1, 16'hB7A4);
    txGet(v, f); chk("R2 first valid", 16'(v), 16'h1); chk("R2 first frame", f, 16'h00A4);
    txGet(v, f); chk("R2 second valid", 16'(v), 16'h1); chk("R2 second frame", f, 16'h00B7);
    txGet(v, f); chk("R2 drained", 16'(v), 16'h0);
  endtask

  task automatic tByteWrite();
    logic v; logic [15:0] f;
    frameLen = 5'd6;
    busWr(1'b0, 16'h5C3E);
    txGet(v, f); chk("R3 short byte frame", f, 16'h003E);
    txGet(v, f); chk("R3 single frame only", 16'(v), 16'h0);
    frameLen = 5'd12;
    busWr(1'b0, 16'hFF81);
    txGet(v, f); chk("R3 long byte valid", 16'(v), 16'h1); chk("R3 long byte frame", f, 16'h0081);
    txGet(v, f); chk("R3 long byte single", 16'(v), 16'h0);
  endtask

  task automatic tRxThreshold();
    logic [15:0] d;
    frameLen = 5'd8; rxThreshOne = 1'b0;
    rxPut(16'h0011);
    chk("R11 level one byte", 16'(rxLevel), 16'h1);
    chk("R6 one byte quiet", 16'(rxNotEmpty), 16'h0);
    rxThreshOne = 1'b1; #1;
    chk("R7 one byte ready", 16'(rxNotEmpty), 16'h1);
    rxThreshOne = 1'b0;
    rxPut(16'h0022);
    chk("R11 level two bytes", 16'(rxLevel), 16'h2);
    chk("R6 two bytes ready", 16'(rxNotEmpty), 16'h1);
    rxPut(16'h0033);
    chk("R11 level three bytes", 16'(rxLevel), 16'h3);
    busRd(1'b1, d);
    chk("R4 packed read order", d, 16'h2211);
    chk("R8 odd remainder level", 16'(rxLevel), 16'h1);
    chk("R8 odd remainder quiet", 16'(rxNotEmpty), 16'h0);
    rxThreshOne = 1'b1; #1;
    chk("R8 threshold raises flag", 16'(rxNotEmpty), 16'h1);
    busRd(1'b0, d);
    chk("R8 last frame", d, 16'h0033);
    chk("R8 aligned empty", 16'(rxLevel), 16'h0);
    rxThreshOne = 1'b0;
  endtask

  task automatic tLoneWide();
    logic [15:0] d;
    rxPut(16'h005A);
    busRd(1'b1, d);
    chk("R5 lone frame", d, 16'h005A);
    chk("R5 popped one", 16'(rxLevel), 16'h0);
  endtask

  task automatic tEmptyRead();
    logic [15:0] d;
    busRd(1'b1, d);
    chk("R12 empty data", d, 16'h0000);
    chk("R12 level unchanged", 16'(rxLevel), 16'h0);
    rxPut(16'h0077);
    busRd(1'b0, d);
    chk("R12 no underflow after", d, 16'h0077);
  endtask

  task automatic tOverflow();
    logic v; logic [15:0] f;
    frameLen = 5'd8;
    busWr(1'b1, 16'h2211);
    busWr(1'b1, 16'h4433);
    chk("R9 no flag when fits", 16'(wrOverflow), 16'h0);
    busWr(1'b0, 16'h0055);
    chk("R9 flag on full", 16'(wrOverflow), 16'h1);
    txGet(v, f); chk("R9 head kept", f, 16'h0011);
    busWr(1'b1, 16'h7766);
    chk("R9 flag sticky", 16'(wrOverflow), 16'h1);
    busWr(1'b0, 16'h0088);
    txGet(v, f); chk("R9 order 2", f, 16'h0022);
    txGet(v, f); chk("R9 order 3", f, 16'h0033);
    txGet(v, f); chk("R9 order 4", f, 16'h0044);
    txGet(v, f); chk("R9 accepted after drop", f, 16'h0088);
    txGet(v, f); chk("R9 nothing extra", 16'(v), 16'h0);
    chk("R9 flag holds", 16'(wrOverflow), 16'h1);
  endtask

  task automatic tLongFrames();
    logic v; logic [15:0] f; logic [15:0] d;
    frameLen = 5'd16; rxThreshOne = 1'b0;
    busWr(1'b1, 16'hBEEF);
    txGet(v, f); chk("R10 tx valid", 16'(v), 16'h1); chk("R10 tx frame", f, 16'hBEEF);
    txGet(v, f); chk("R10 tx single", 16'(v), 16'h0);
    rxPut(16'hC0DE);
    chk("R10 two slots", 16'(rxLevel), 16'h2);
    chk("R10 flag", 16'(rxNotEmpty), 16'h1);
    busRd(1'b1, d);
    chk("R10 rx frame", d, 16'hC0DE);
    chk("R10 rx empty", 16'(rxLevel), 16'h0);
    rxPut(16'h1234);
    busRd(1'b0, d);
    chk("R3 long byte read", d, 16'h0034);
    chk("R3 long byte pops frame", 16'(rxLevel), 16'h0);
  endtask

  task automatic tRxDrop();
    logic [15:0] d;
    frameLen = 5'd8;
    rxPut(16'h00A1); rxPut(16'h00A2); rxPut(16'h00A3); rxPut(16'h00A4);
    rxPut(16'h00A5);
    chk("R13 full level", 16'(rxLevel), 16'h3);
    busRd(1'b1, d); chk("R13 first pair", d, 16'hA2A1);
    busRd(1'b1, d); chk("R13 second pair", d, 16'hA4A3);
    chk("R13 dropped frame absent", 16'(rxLevel), 16'h0);
  endtask

  initial begin
    tReset();
    tPackedWrite();
    tByteWrite();
    tRxThreshold();
    tLoneWide();
    tEmptyRead();
    tOverflow();
    tLongFrames();
    tRxDrop();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule